// File: doc/BRIEF.md
# Serial Management Register Responder

This block sits behind a software-visible serial control register and plays the part of a physical-layer device on a two-wire management bus. Software toggles a clock bit, a data-out bit and a read-mode bit by register writes. The block samples them once per system clock and watches the management clock bit for rising transitions. On each rising transition it shifts one bit into a 32-bit shift word and advances a bit counter. Its single output is a data-in bit that software reads back.

Frames are checked at two fixed points in the bit count. At 16 bits the header is decoded, and a read loads the addressed device register into the shift word so that later clocks shift it out. At 32 bits the full frame is decoded, and a write updates the addressed register through a fixed writable-bit mask. A run of ones that fills the whole shift word puts the counter back to zero, so a long preamble of ones always lines the block up with the next frame. Only device address 1 answers.

Top module: `mii_mgmt_responder`

## Requirements
- R1: After reset the data-in output is 0 and the register file holds 0x3100 in register 0, 0xF02C in register 1, 0x7810 in register 2, 0x0501 in register 4, 0x4181 in register 5, 0x0003 in register 16, 0x0001 in register 18 and 0x0000 in every other register.
- R2: Only a rising transition of the sampled management clock (a 1 after a 0 on the previous system clock) advances the block. A clock level held high for many system clocks counts as one bit, and no state or output changes between transitions.
- R3: A transition shifts the word left by one and inserts a 1 at bit 0 only when data-out is 1 and either the updated count is below 16 or read mode is 0. In read mode from count 16 on, a 0 is inserted.
- R4: On every transition whose updated count is 16 or more while read mode is 1, the data-in output takes bit 15 of the shifted word. For a read, the k-th transition after the 16-bit header (k = 1..15) presents bit 15-k of the addressed register.
- R5: When the shifted word is all ones the counter returns to 0, and no decode takes place on that transition.
- R6: At count 16 the header is read MSB first as opcode in bits 15:12, device address in bits 11:7 and register in bits 6:2. Opcode 0110 loads the addressed register value, zero-extended, into the shift word.
- R7: A read header whose device address is not 1 loads 0 into the shift word, so the data-in bits that follow are 0.
- R8: At count 32 the frame is read as opcode in bits 31:28, device address in bits 27:23, register in bits 22:18 and data in bits 15:0. Opcode 0101 with address 1 sets the register to (old AND NOT mask) OR (data AND mask). The mask is 0xFFFF for registers 1, 2, 3, 5, 6 and 18 to 25, 0xC01F for register 4, 0x0FFF for register 16, and 0x0000 for all others.
- R9: A write frame whose device address is not 1 leaves every register unchanged.
- R10: The counter saturates, and past count 32 no transition decodes anything until an all-ones word resynchronises the block.
- R11: A full 32-bit frame with an opcode other than 0101 writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc_i | input | 1 | Management clock level sampled from the serial register |
| mdo_i | input | 1 | Data bit driven by software |
| rd_mode_i | input | 1 | High while software is receiving read data |
| mdi_o | output | 1 | Data bit returned to software |

## Verification
The assertions rely on the management clock input being held low through reset, so that the first high level counts as a genuine transition. They also rely on read mode being raised only after the 16 header bits, since the insertion rule would otherwise alter the header. The bench drives every bit as a low phase of two system clocks followed by a high phase of at least one clock. It starts each read or write with 32 ones and raises read mode only for the data half of a read. Register values it writes are chosen so that no read-back word happens to form a valid write frame at count 32.

// File: rtl/mii_resp_pkg.sv
package mii_resp_pkg;

  localparam int WORD_W  = 32;
  localparam int HDR_BITS = 16;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 5;
  localparam int NREGS   = 32;

  // Power-on contents of the device register file.
  function automatic logic [DATA_W-1:0] reg_reset_val(input int idx);
    logic [DATA_W-1:0] v;
    case (idx)
      0:       v = 16'h3100;
      1:       v = 16'hF02C;
      2:       v = 16'h7810;
      4:       v = 16'h0501;
      5:       v = 16'h4181;
      16:      v = 16'h0003;
      18:      v = 16'h0001;
      default: v = '0;
    endcase
    return v;
  endfunction

  // Bits a write frame may change in each register.
  function automatic logic [DATA_W-1:0] reg_wmask(input int idx);
    logic [DATA_W-1:0] m;
    if ((idx >= 1 && idx <= 3) || idx == 5 || idx == 6 || (idx >= 18 && idx <= 25))
      m = 16'hFFFF;
    else if (idx == 4)
      m = 16'hC01F;
    else if (idx == 16)
      m = 16'h0FFF;
    else
      m = '0;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] masked_merge(input logic [DATA_W-1:0] old_v,
                                                     input logic [DATA_W-1:0] new_v,
                                                     input logic [DATA_W-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  typedef struct packed {
    logic [3:0]        op;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regn;
  } mgmt_cmd_t;

  function automatic mgmt_cmd_t hdr_fields(input logic [WORD_W-1:0] w);
    mgmt_cmd_t c;
    c.op   = w[15:12];
    c.phy  = w[11:7];
    c.regn = w[6:2];
    return c;
  endfunction

  function automatic mgmt_cmd_t frame_fields(input logic [WORD_W-1:0] w);
    mgmt_cmd_t c;
    c.op   = w[31:28];
    c.phy  = w[27:23];
    c.regn = w[22:18];
    return c;
  endfunction

endpackage

// File: rtl/mii_clk_edge.sv
module mii_clk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/mii_shift_core.sv
module mii_shift_core
  import mii_resp_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_i,
  input  logic                 mdo_i,
  input  logic                 rd_mode_i,
  input  logic                 load_i,
  input  logic [DATA_W-1:0]    load_val_i,
  output logic [CNT_W-1:0]     cnt_nxt_o,
  output logic [WORD_W-1:0]    word_nxt_o,
  output logic                 all_ones_o,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 mdi_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] HDR_CNT = CNT_W'(HDR_BITS);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] word_q;
  logic              mdi_q;
  logic [CNT_W-1:0]  cnt_inc;
  logic              in_bit;
  logic [WORD_W-1:0] word_sh;
  logic              drive_mdi;

  always_comb begin
    cnt_inc   = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    in_bit    = mdo_i & ((cnt_inc < HDR_CNT) | ~rd_mode_i);
    word_sh   = {word_q[WORD_W-2:0], in_bit};
    drive_mdi = rd_mode_i & (cnt_inc >= HDR_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      word_q <= '0;
      mdi_q  <= 1'b0;
    end else if (step_i) begin
      cnt_q  <= (&word_sh) ? '0 : cnt_inc;
      word_q <= load_i ? {{(WORD_W-DATA_W){1'b0}}, load_val_i} : word_sh;
      if (drive_mdi) mdi_q <= word_sh[HDR_BITS-1];
    end
  end

  assign cnt_nxt_o  = cnt_inc;
  assign word_nxt_o = word_sh;
  assign all_ones_o = &word_sh;
  assign cnt_o      = cnt_q;
  assign mdi_o      = mdi_q;
endmodule

// File: rtl/mii_phy_regs.sv
module mii_phy_regs
  import mii_resp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [NREGS];
  logic [DATA_W-1:0] regs_d [NREGS];

  for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
    localparam logic [DATA_W-1:0] WMASK = reg_wmask(gi);
    logic hit;
    assign hit        = we_i && (waddr_i == ADDR_W'(gi));
    assign regs_d[gi] = hit ? masked_merge(regs_q[gi], wdata_i, WMASK) : regs_q[gi];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= reg_reset_val(i);
    end else begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= regs_d[i];
    end
  end

  assign rdata_o = regs_q[raddr_i];
endmodule

// File: rtl/mii_mgmt_responder.sv
module mii_mgmt_responder
  import mii_resp_pkg::*;
#(
  parameter int              CNT_W    = 6,
  parameter logic [4:0]      PHY_ID   = 5'd1,
  parameter logic [3:0]      OP_READ  = 4'b0110,
  parameter logic [3:0]      OP_WRITE = 4'b0101
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_i,
  input  logic mdo_i,
  input  logic rd_mode_i,
  output logic mdi_o
);
  localparam logic [CNT_W-1:0] HDR_CNT   = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(WORD_W);

  logic              mdc_rise;
  logic              all_ones;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] word_nxt;
  logic              rd_load;
  logic              wr_en;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] load_val;
  mgmt_cmd_t         hdr_cmd;
  mgmt_cmd_t         full_cmd;
  logic              at_hdr;
  logic              at_full;
  logic              unused_ta_bits;

  mii_clk_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (mdc_i),
    .rise_o  (mdc_rise)
  );

  mii_shift_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (mdc_rise),
    .mdo_i      (mdo_i),
    .rd_mode_i  (rd_mode_i),
    .load_i     (rd_load),
    .load_val_i (load_val),
    .cnt_nxt_o  (cnt_nxt),
    .word_nxt_o (word_nxt),
    .all_ones_o (all_ones),
    .cnt_o      (cnt_q),
    .mdi_o      (mdi_o)
  );

  always_comb begin
    hdr_cmd  = hdr_fields(word_nxt);
    full_cmd = frame_fields(word_nxt);
    at_hdr   = mdc_rise && !all_ones && (cnt_nxt == HDR_CNT);
    at_full  = mdc_rise && !all_ones && (cnt_nxt == FRAME_CNT);
    rd_load  = at_hdr && (hdr_cmd.op == OP_READ);
    load_val = (hdr_cmd.phy == PHY_ID) ? rd_val : '0;
    wr_en    = at_full && (full_cmd.op == OP_WRITE) && (full_cmd.phy == PHY_ID);
  end

  assign unused_ta_bits = ^word_nxt[17:16];

  mii_phy_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (wr_en),
    .waddr_i (full_cmd.regn),
    .wdata_i (word_nxt[DATA_W-1:0]),
    .raddr_i (hdr_cmd.regn),
    .rdata_o (rd_val)
  );
endmodule

// File: rtl/mii_resp_chk.sv
module mii_resp_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step,
  input logic             all_ones,
  input logic             rd_load,
  input logic             wr_en,
  input logic [CNT_W-1:0] cnt_q,
  input logic             mdi
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R2
  mdi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(mdi));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q));

  // R5
  resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && all_ones) |=> (cnt_q == '0));

  // R6
  rd_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> (cnt_q == CNT_W'(16)));

  // R8
  wr_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt_q == CNT_W'(32)));

  // R10
  sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !all_ones && cnt_q == CMAX) |=> (cnt_q == CMAX));

  // R11
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_load, wr_en}));
endmodule

bind mii_mgmt_responder mii_resp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .step     (mdc_rise),
  .all_ones (all_ones),
  .rd_load  (rd_load),
  .wr_en    (wr_en),
  .cnt_q    (cnt_q),
  .mdi      (mdi_o)
);

// File: tb/tb_mii_mgmt_responder.sv
module tb_mii_mgmt_responder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdc = 1'b0;
  logic mdo = 1'b0;
  logic rd_mode = 1'b0;
  logic mdi;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] model [32];

  always #2.5 clk = ~clk;

  mii_mgmt_responder dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc_i     (mdc),
    .mdo_i     (mdo),
    .rd_mode_i (rd_mode),
    .mdi_o     (mdi)
  );

  function automatic logic [15:0] exp_reset(input int i);
    if (i == 0)  return 16'h3100;
    if (i == 1)  return 16'hF02C;
    if (i == 2)  return 16'h7810;
    if (i == 4)  return 16'h0501;
    if (i == 5)  return 16'h4181;
    if (i == 16) return 16'h0003;
    if (i == 18) return 16'h0001;
    return 16'h0000;
  endfunction

  function automatic logic [15:0] exp_mask(input int i);
    if (i == 4)  return 16'hC01F;
    if (i == 16) return 16'h0FFF;
    if (i inside {[1:3], 5, 6, [18:25]}) return 16'hFFFF;
    return 16'h0000;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic rd, input int hold);
    @(negedge clk);
    mdo = b; rd_mode = rd; mdc = 1'b0;
    repeat (2) @(negedge clk);
    mdc = 1'b1;
    repeat (hold) @(negedge clk);
  endtask

  task automatic preamble();
    for (int i = 0; i < 32; i++) send_bit(1'b1, 1'b0, 1);
  endtask

  task automatic send_raw32(input logic [31:0] f);
    for (int i = 31; i >= 0; i--) send_bit(f[i], 1'b0, 1);
  endtask

  task automatic do_write(input logic [4:0] phy, input logic [4:0] r, input logic [15:0] d);
    preamble();
    send_raw32({4'b0101, phy, r, 2'b10, d});
  endtask

  task automatic do_read(input logic [4:0] phy, input logic [4:0] r, input logic drive,
                         input int hold, output logic [14:0] got);
    logic [15:0] h;
    h = {4'b0110, phy, r, 2'b00};
    preamble();
    for (int i = 15; i >= 0; i--) send_bit(h[i], 1'b0, 1);
    for (int k = 1; k <= 15; k++) begin
      send_bit(drive, 1'b1, hold);
      got[15-k] = mdi;
    end
    send_bit(drive, 1'b1, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [14:0] got;
    for (int i = 0; i < 32; i++) model[i] = exp_reset(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset output
    check(mdi == 1'b0, "R1 mdi after reset", mdi, 0);

    // R1 R4 R6: sweep all registers at reset values
    for (int r = 0; r < 32; r++) begin
      do_read(5'd1, 5'(r), 1'b0, 1, got);
      check(got == model[r][14:0], $sformatf("R1 R4 R6 read reg %0d", r), got, model[r][14:0]);
    end

    // R7: other device addresses read as zero
    for (int p = 0; p < 4; p++) begin
      logic [4:0] phy;
      phy = (p == 0) ? 5'd0 : (p == 1) ? 5'd2 : (p == 2) ? 5'd31 : 5'd17;
      for (int r = 0; r < 3; r++) begin
        do_read(phy, 5'(r + 1), 1'b0, 1, got);
        check(got == 15'd0, $sformatf("R7 read phy %0d reg %0d", phy, r + 1), got, 0);
      end
    end

    // R8: masked writes across the whole file
    for (int r = 0; r < 32; r++) begin
      do_write(5'd1, 5'(r), 16'hA5C3);
      model[r] = (model[r] & ~exp_mask(r)) | (16'hA5C3 & exp_mask(r));
    end
    for (int r = 0; r < 32; r++) begin
      do_read(5'd1, 5'(r), 1'b0, 1, got);
      check(got == model[r][14:0], $sformatf("R8 masked write reg %0d", r), got, model[r][14:0]);
    end

    // R9: writes to another device address ignored
    for (int r = 0; r < 8; r++) do_write(5'd3, 5'(r), 16'h3C5A);
    for (int r = 0; r < 8; r++) begin
      do_read(5'd1, 5'(r), 1'b0, 1, got);
      check(got == model[r][14:0], $sformatf("R9 foreign write reg %0d", r), got, model[r][14:0]);
    end

    // R2: second sweep read back with long high phases
    for (int r = 0; r < 32; r++) begin
      do_write(5'd1, 5'(r), 16'h3C5A);
      model[r] = (model[r] & ~exp_mask(r)) | (16'h3C5A & exp_mask(r));
    end
    for (int r = 0; r < 32; r += 3) begin
      do_read(5'd1, 5'(r), 1'b0, 6, got);
      check(got == model[r][14:0], $sformatf("R2 held clock reg %0d", r), got, model[r][14:0]);
    end

    // R3: data-out high during read phase must not enter the word
    do_read(5'd1, 5'd2, 1'b1, 1, got);
    check(got == model[2][14:0], "R3 read with mdo high", got, model[2][14:0]);
    for (int k = 0; k < 4; k++) begin
      send_bit(1'b1, 1'b1, 1);
      check(mdi == 1'b0, $sformatf("R3 trailing bit %0d", k), mdi, 0);
    end

    // R5: garbage then preamble resynchronises
    for (int i = 0; i < 21; i++) send_bit(1'(i % 3 == 0), 1'b0, 1);
    do_read(5'd1, 5'd5, 1'b0, 1, got);
    check(got == model[5][14:0], "R5 resync after garbage", got, model[5][14:0]);

    // R10: a second frame without preamble is not decoded
    do_write(5'd1, 5'd1, 16'h1111);
    model[1] = 16'h1111;
    send_raw32({4'b0101, 5'd1, 5'd1, 2'b10, 16'h2222});
    do_read(5'd1, 5'd1, 1'b0, 1, got);
    check(got == model[1][14:0], "R10 saturated frame ignored", got, model[1][14:0]);

    // R11: full frame with a non-write opcode changes nothing
    preamble();
    send_raw32({4'b0111, 5'd1, 5'd1, 2'b10, 16'h4444});
    do_read(5'd1, 5'd1, 1'b0, 1, got);
    check(got == model[1][14:0], "R11 other opcode no write", got, model[1][14:0]);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule